// File: doc/BRIEF.md
# Complex Multiplier with Rounding, Saturation and Power Detection

This block multiplies a stream of complex samples by a second stream of complex reference samples, one pair per clock, as needed when a signal is multiplied by a reference function during compression. Each operand has a signed 16-bit real part and a signed 16-bit imaginary part. The full-precision result is scaled down by a per-sample shift, rounded, and clamped back to 16 bits for each of its two parts.

A per-sample mode bit reuses the same four multipliers for power detection. In that mode the block takes the input sample times itself and sums the two squares to give the squared magnitude on the real output. The imaginary output is zero and the reference operand has no effect. Samples enter with a valid bit, and results leave with a valid bit after a fixed pipeline delay. The block applies no backpressure.

Top module: `cmplx_mul_rs`

## Requirements
- R1: In multiply mode (`det_mode`=0), with shift 0 and no clipping, `out_re` = a_re·b_re − a_im·b_im and `out_im` = a_re·b_im + a_im·b_re, with sums formed at 33 bits.
- R2: A sample accepted at a rising edge (in_valid=1) produces `out_valid`=1 with its result after the third rising edge counting that one, and a new sample is accepted on every clock.
- R3: For shift k in 1..16, each 33-bit sum S becomes floor((S + 2^(k−1)) / 2^k), so halves round toward positive infinity. With k=0, S is passed through unchanged.
- R4: A rounded value above 32767 is output as 32767 (0x7FFF). A rounded value below −32768 is output as −32768 (0x8000).
- R5: Shift codes 17 to 31 on the 5-bit `shift` port act exactly like 16.
- R6: In detect mode (`det_mode`=1), `out_re` is a_re² + a_im², with the same shift, rounding and clipping as R3/R4, and `out_im` is 0. The reference inputs have no effect.
- R7: Mode and shift are captured with each sample, so a change between back-to-back samples applies only to the samples that carry it.
- R8: While in reset, and in any cycle with `out_valid`=0, `out_valid`, `out_re` and `out_im` are all 0.
- R9: Cycles with in_valid=0 produce no output, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operands are valid this cycle |
| det_mode | input | 1 | 0 = complex multiply, 1 = squared-magnitude detect |
| shift | input | 5 | Right shift before rounding (0..16, larger acts as 16) |
| a_re | input | 16 | Input sample, real part, signed |
| a_im | input | 16 | Input sample, imaginary part, signed |
| b_re | input | 16 | Reference sample, real part, signed |
| b_im | input | 16 | Reference sample, imaginary part, signed |
| out_valid | output | 1 | Result valid |
| out_re | output | 16 | Result real part, signed |
| out_im | output | 16 | Result imaginary part, signed |

## Verification
The bench drives exact half-way values in both signs. A design that truncates, or rounds symmetrically away from zero, gives −2 instead of −1 for −3/2. It also drives full-scale negative operands, whose product or sum of squares crosses +32767. A design that wraps instead of clipping flips the sign there. Detect-mode samples carry random reference data and alternate with multiply samples on consecutive cycles. A design that registers the mode late, or lets the reference leak into detection, shows the wrong function or a nonzero imaginary part. Shift codes above 16 are compared against the same sample at 16, which exposes a shifter that wraps or under-scales.

// File: rtl/cmplx_mul_pkg.sv
package cmplx_mul_pkg;
  // Default widths for the datapath
  localparam int CM_DW    = 16;
  localparam int CM_MAXSH = 16;
  localparam int CM_SHW   = $clog2(CM_MAXSH + 1);

  typedef enum logic {
    CM_MODE_MUL = 1'b0,
    CM_MODE_DET = 1'b1
  } cm_mode_e;
endpackage

// File: rtl/cmplx_mul_prod.sv
// Stage 1: operand selection and four signed partial products.
module cmplx_mul_prod
  import cmplx_mul_pkg::*;
#(
  parameter int DW  = CM_DW,
  parameter int SHW = CM_SHW,
  localparam int PW = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_in,
  input  logic                 det_in,
  input  logic [SHW-1:0]       sh_in,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  output logic                 v_q,
  output logic                 det_q,
  output logic [SHW-1:0]       sh_q,
  output logic signed [PW-1:0] prod_q [4]
);
  // Product index map: 0 = a_re*y0, 1 = a_im*y1, 2 = a_re*b_im, 3 = a_im*b_re
  // In detect mode y0/y1 become the input itself, giving the two squares.
  for (genvar g = 0; g < 4; g++) begin : g_mul
    logic signed [DW-1:0] opx;
    logic signed [DW-1:0] opy;
    assign opx = (g % 2 == 0) ? a_re : a_im;
    if (g == 0) begin : g_y0
      assign opy = (det_in == CM_MODE_DET) ? a_re : b_re;
    end else if (g == 1) begin : g_y1
      assign opy = (det_in == CM_MODE_DET) ? a_im : b_im;
    end else if (g == 2) begin : g_y2
      assign opy = b_im;
    end else begin : g_y3
      assign opy = b_re;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q[g] <= '0;
      else        prod_q[g] <= opx * opy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      det_q <= 1'b0;
      sh_q  <= '0;
    end else begin
      v_q   <= v_in;
      det_q <= det_in;
      sh_q  <= sh_in;
    end
  end
endmodule

// File: rtl/cmplx_mul_sum.sv
// Stage 2: combine partial products into full-precision real/imag sums.
module cmplx_mul_sum
  import cmplx_mul_pkg::*;
#(
  parameter int DW  = CM_DW,
  parameter int SHW = CM_SHW,
  localparam int PW = 2 * DW,
  localparam int SW = PW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_in,
  input  logic                 det_in,
  input  logic [SHW-1:0]       sh_in,
  input  logic signed [PW-1:0] prod_in [4],
  output logic                 v_q,
  output logic                 det_q,
  output logic [SHW-1:0]       sh_q,
  output logic signed [SW-1:0] sum_re_q,
  output logic signed [SW-1:0] sum_im_q
);
  logic signed [SW-1:0] p0, p1, p2, p3;
  logic signed [SW-1:0] re_nx, im_nx;

  assign p0 = SW'(prod_in[0]);
  assign p1 = SW'(prod_in[1]);
  assign p2 = SW'(prod_in[2]);
  assign p3 = SW'(prod_in[3]);

  always_comb begin
    if (det_in == CM_MODE_DET) begin
      re_nx = p0 + p1;
      im_nx = '0;
    end else begin
      re_nx = p0 - p1;
      im_nx = p2 + p3;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q      <= 1'b0;
      det_q    <= 1'b0;
      sh_q     <= '0;
      sum_re_q <= '0;
      sum_im_q <= '0;
    end else begin
      v_q      <= v_in;
      det_q    <= det_in;
      sh_q     <= sh_in;
      sum_re_q <= re_nx;
      sum_im_q <= im_nx;
    end
  end

  // R6: a squared magnitude is never negative
  det_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && det_q) |-> (sum_re_q >= 0));
endmodule

// File: rtl/cmplx_mul_rnd.sv
// Stage 3: scale, round half up, clip to the output width.
module cmplx_mul_rnd
  import cmplx_mul_pkg::*;
#(
  parameter int DW    = CM_DW,
  parameter int SHW   = CM_SHW,
  parameter int MAXSH = CM_MAXSH,
  localparam int SW   = 2 * DW + 1,
  localparam int RW   = SW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_in,
  input  logic                 det_in,
  input  logic [SHW-1:0]       sh_in,
  input  logic signed [SW-1:0] sum_re,
  input  logic signed [SW-1:0] sum_im,
  output logic                 out_valid,
  output logic                 out_det,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);
  localparam logic signed [RW-1:0] LIM_HI = RW'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [RW-1:0] LIM_LO = -RW'(64'sd1 <<< (DW - 1));
  localparam logic signed [DW-1:0] OUT_HI = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] OUT_LO = {1'b1, {(DW-1){1'b0}}};

  function automatic logic signed [RW-1:0] shift_round(
    input logic signed [SW-1:0] s, input logic [SHW-1:0] k);
    logic signed [RW-1:0] ext;
    logic signed [RW-1:0] half;
    ext = RW'(s);
    if (k == '0) return ext;
    half = RW'(1) <<< (k - 1'b1);
    return (ext + half) >>> k;
  endfunction

  function automatic logic signed [DW-1:0] clip(
    input logic signed [RW-1:0] r, input logic hi, input logic lo);
    if (hi) return OUT_HI;
    if (lo) return OUT_LO;
    return r[DW-1:0];
  endfunction

  logic [SHW-1:0]       k_eff;
  logic signed [RW-1:0] rnd_re, rnd_im;
  logic                 sat_hi_re, sat_lo_re, sat_hi_im, sat_lo_im;

  assign k_eff     = (sh_in > SHW'(MAXSH)) ? SHW'(MAXSH) : sh_in;
  assign rnd_re    = shift_round(sum_re, k_eff);
  assign rnd_im    = shift_round(sum_im, k_eff);
  assign sat_hi_re = rnd_re > LIM_HI;
  assign sat_lo_re = rnd_re < LIM_LO;
  assign sat_hi_im = rnd_im > LIM_HI;
  assign sat_lo_im = rnd_im < LIM_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_det   <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else if (!v_in) begin
      out_valid <= 1'b0;
      out_det   <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= 1'b1;
      out_det   <= det_in;
      out_re    <= clip(rnd_re, sat_hi_re, sat_lo_re);
      out_im    <= clip(rnd_im, sat_hi_im, sat_lo_im);
    end
  end

  // R4
  sat_hi_re_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_in && sat_hi_re) |=> (out_re == OUT_HI));
  // R4
  sat_lo_re_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_in && sat_lo_re) |=> (out_re == OUT_LO));
  // R4
  sat_hi_im_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_in && sat_hi_im) |=> (out_im == OUT_HI));
  // R6
  det_im_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_det) |-> (out_im == '0));
endmodule

// File: rtl/cmplx_mul_rs.sv
// Top: three-stage complex multiplier / power detector.
module cmplx_mul_rs
  import cmplx_mul_pkg::*;
#(
  parameter int DW    = CM_DW,
  parameter int MAXSH = CM_MAXSH,
  parameter int SHW   = 5,
  localparam int PW   = 2 * DW,
  localparam int SW   = PW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 det_mode,
  input  logic [SHW-1:0]       shift,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im
);
  logic                 v1, det1, v2, det2, det3;
  logic [SHW-1:0]       sh1, sh2;
  logic signed [PW-1:0] prod [4];
  logic signed [SW-1:0] sum_re, sum_im;

  cmplx_mul_prod #(.DW(DW), .SHW(SHW)) u_prod (
    .clk(clk), .rst_n(rst_n), .v_in(in_valid), .det_in(det_mode),
    .sh_in(shift), .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .v_q(v1), .det_q(det1), .sh_q(sh1), .prod_q(prod)
  );

  cmplx_mul_sum #(.DW(DW), .SHW(SHW)) u_sum (
    .clk(clk), .rst_n(rst_n), .v_in(v1), .det_in(det1), .sh_in(sh1),
    .prod_in(prod), .v_q(v2), .det_q(det2), .sh_q(sh2),
    .sum_re_q(sum_re), .sum_im_q(sum_im)
  );

  cmplx_mul_rnd #(.DW(DW), .SHW(SHW), .MAXSH(MAXSH)) u_rnd (
    .clk(clk), .rst_n(rst_n), .v_in(v2), .det_in(det2), .sh_in(sh2),
    .sum_re(sum_re), .sum_im(sum_im), .out_valid(out_valid),
    .out_det(det3), .out_re(out_re), .out_im(out_im)
  );

  // Edges seen since reset release, saturating at 3 (assertion support)
  logic [1:0] edges_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               edges_q <= '0;
    else if (edges_q != 2'd3) edges_q <= edges_q + 2'd1;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q == 2'd3 && $past(in_valid, 3)) |-> out_valid);
  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (edges_q == 2'd3 && $past(in_valid, 3)));
  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_re == '0 && out_im == '0));
endmodule

// File: tb/cmplx_mul_rs_bench.sv
module cmplx_mul_rs_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic det_mode = 1'b0;
  logic [4:0] shift = '0;
  logic signed [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic out_valid;
  logic signed [15:0] out_re, out_im;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;  // 50 MHz

  cmplx_mul_rs u_cmplx_mul_rs (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .det_mode(det_mode),
    .shift(shift), .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  // Reference arithmetic, done in 64-bit integers
  function automatic longint scale(longint s, int k);
    longint r;
    longint d;
    if (k > 16) k = 16;
    if (k == 0) r = s;
    else begin
      d = longint'(1) << k;
      r = s + d / 2;
      // floor division
      if (r >= 0) r = r / d;
      else r = -((-r + d - 1) / d);
    end
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  // Model pipeline: three slots, slot 2 is what the outputs should show
  bit      mv [3];
  longint  mre [3];
  longint  mim [3];
  string   mtag [3];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin mv[i] <= 0; mre[i] <= 0; mim[i] <= 0; mtag[i] <= "R8"; end
    end else begin
      longint sr, si;
      if (det_mode) begin
        sr = longint'(a_re) * a_re + longint'(a_im) * a_im;
        si = 0;
      end else begin
        sr = longint'(a_re) * b_re - longint'(a_im) * b_im;
        si = longint'(a_re) * b_im + longint'(a_im) * b_re;
      end
      mv[2] <= mv[1];  mre[2] <= mre[1];  mim[2] <= mim[1];  mtag[2] <= mtag[1];
      mv[1] <= mv[0];  mre[1] <= mre[0];  mim[1] <= mim[0];  mtag[1] <= mtag[0];
      mv[0] <= in_valid;
      mre[0] <= in_valid ? scale(sr, int'(shift)) : 0;
      mim[0] <= in_valid ? scale(si, int'(shift)) : 0;
      mtag[0] <= in_valid ? cur_tag : "R9";
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    checks++;
    if (!rst_n) begin
      if (out_valid !== 1'b0 || out_re !== 16'sd0 || out_im !== 16'sd0) begin
        errors++;
        $display("FAIL R8 reset: valid=%0b re=%0d im=%0d expected 0 0 0",
                 out_valid, out_re, out_im);
      end
    end else if (out_valid !== mv[2] || longint'(out_re) != mre[2] ||
                 longint'(out_im) != mim[2]) begin
      errors++;
      $display("FAIL %s: valid=%0b re=%0d im=%0d expected valid=%0b re=%0d im=%0d",
               mtag[2], out_valid, out_re, out_im, mv[2], mre[2], mim[2]);
    end
  end

  task automatic send(input int ar, input int ai, input int br, input int bi,
                      input bit det, input int sh, input string tag);
    @(negedge clk);
    #1;
    in_valid = 1'b1; det_mode = det; shift = 5'(sh);
    a_re = 16'(ar); a_im = 16'(ai); b_re = 16'(br); b_im = 16'(bi);
    cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      in_valid = 1'b0; det_mode = 1'($urandom); shift = 5'($urandom);
      a_re = 16'($urandom); a_im = 16'($urandom);
      b_re = 16'($urandom); b_im = 16'($urandom);
      cur_tag = "R9";
    end
  endtask

  bit done = 0;
  initial begin
    #400000;  // watchdog, 20000 cycles
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R8: reset state observed by the negedge checker for several cycles
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(3);

    // R1: exact products at shift 0
    send(3, 2, 5, -7, 0, 0, "R1");
    send(-100, 45, 12, 33, 0, 0, "R1");
    send(0, 0, 1234, -999, 0, 0, "R1");
    send(1, -1, -1, 1, 0, 0, "R1");
    idle(3);

    // R3: half-way values in both signs, several shifts
    send(3, 0, 1, 0, 0, 1, "R3");     // 3/2  -> 2
    send(-3, 0, 1, 0, 0, 1, "R3");    // -3/2 -> -1
    send(5, 0, 1, 1, 0, 2, "R3");     // re 5/4 -> 1, im 5/4 -> 1
    send(-6, 0, 1, 0, 0, 2, "R3");    // -6/4 -> -1
    send(-2, 0, 1, 0, 0, 2, "R3");    // -2/4 -> 0
    send(32767, 32767, 32767, -32768, 0, 16, "R3");
    send(-20000, 17, 31000, -5, 0, 15, "R3");
    idle(2);

    // R4: saturation both ways
    send(-32768, 0, -32768, 0, 0, 0, "R4");          // 2^30 -> 32767
    send(-32768, 0, 32767, 0, 0, 0, "R4");           // big negative -> -32768
    send(-32768, -32768, -32768, 32767, 0, 15, "R4");
    send(32767, 32767, 32767, 32767, 0, 14, "R4");   // im clips high
    send(-32768, -32768, -32768, -32768, 0, 15, "R4"); // im 2^31 >> 15 = 65536 -> clip
    idle(2);

    // R5: shift codes above 16 act as 16
    send(30000, -30000, 29999, 12345, 0, 16, "R5");
    send(30000, -30000, 29999, 12345, 0, 17, "R5");
    send(30000, -30000, 29999, 12345, 0, 31, "R5");
    send(-32768, -32768, 0, 0, 1, 24, "R5");
    idle(2);

    // R6: detection with random reference
    send(3, 4, 777, -888, 1, 0, "R6");               // 25
    send(-32768, -32768, -1, 5, 1, 0, "R6");         // clips to 32767
    send(-32768, -32768, 12, 12, 1, 16, "R6");       // 2^31/2^16 = 32768 -> clip
    send(1000, -1000, 4, 4, 1, 8, "R6");
    for (int i = 0; i < 20; i++)
      send(int'($urandom) % 65536 - 32768, int'($urandom) % 65536 - 32768,
           int'($urandom), int'($urandom), 1, int'($urandom_range(0, 16)), "R6");
    idle(2);

    // R7: mode and shift change every sample, back to back
    for (int i = 0; i < 40; i++)
      send(int'($urandom) % 65536 - 32768, int'($urandom) % 65536 - 32768,
           int'($urandom) % 65536 - 32768, int'($urandom) % 65536 - 32768,
           1'(i), (i * 7) % 20, "R7");
    idle(2);

    // R2: long back-to-back stream, then gappy traffic (R9)
    for (int i = 0; i < 200; i++)
      send(int'($urandom) % 65536 - 32768, int'($urandom) % 65536 - 32768,
           int'($urandom) % 65536 - 32768, int'($urandom) % 65536 - 32768,
           0, int'($urandom_range(12, 16)), "R2");
    for (int i = 0; i < 60; i++) begin
      send(int'($urandom) % 65536 - 32768, int'($urandom) % 65536 - 32768,
           int'($urandom) % 65536 - 32768, int'($urandom) % 65536 - 32768,
           1'($urandom), int'($urandom_range(0, 31)), "R9");
      idle(int'($urandom_range(1, 3)));
    end
    idle(6);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule